// File: doc/BRIEF.md
# External Chip-Select Single-Access Cycle Controller

This block runs one read or one write at a time on a single external chip-select channel. It has a 20-bit address and a 32-bit data path. It drives an active-low chip enable, a read strobe and a write strobe. It also handles one shared handshake pin, which is either an acknowledge pulse from the controller or a ready/acknowledge input from the device. The data bus and the handshake pin are presented as separate input, output and output-enable signals, so a pad ring can combine them.

A request is accepted only while the controller is idle. The configuration word is captured when the request is accepted and governs that whole access. In the timed modes (normal and page) the controller counts a programmed number of wait cycles, then drives the handshake pin low for one cycle. That pulse marks the point where read data is captured or write data is released. In the device-paced modes (external-acknowledge and ready) the controller releases the pin and waits for the device, after a minimum number of wait cycles. Completion is signalled by a one-cycle done pulse.

The states are as follows:
- IDLE: waiting for a request. Go to ADDR if the setup count is nonzero, else to STRB.
- ADDR: setup cycles with chip enable low and no strobe. Go to STRB when the setup count is reached.
- STRB: strobe asserted, counting wait cycles.
  - Timed mode: go to ACK when the wait count is reached.
  - Device-paced mode: once the wait count is reached, go to END on a read or to WHOLD on a write, when the pin condition is met.
- ACK: handshake pulse cycle. Go to RLAT on a read or to WPOST on a write.
- RLAT: read data is captured at the end of this cycle. Go to END.
- WPOST: write strobe still low. Go to WHOLD.
- WHOLD: write strobe high, chip enable and data still driven. Go to END.
- END: chip enable high and done asserted. Go to IDLE.

Top module: `ext_cs_cycle_ctrl`

## Requirements
- R1: While reset is asserted, ce_n, oe_n and we_n are high, done is low and ack_pin_oe is low (the pin is an input).
- R2: With cfg_dyn=0 (static pin mode), ack_pin_oe stays low for the whole of any access.
- R3: With cfg_dyn=1 and cfg_mode 0 (normal) or 1 (page), ack_pin_oe stays high. ack_pin_o is low for exactly one cycle, namely cycle s+w+2 after the accepting edge (s = cfg_setup, w = cfg_wait).
- R4: In a timed read, rd_data takes the data_i value present at the rising edge that ends the cycle after the ACK cycle.
- R5: In a timed read, ce_n and oe_n go high in the cycle after read data is captured, and done is high for exactly that one cycle.
- R6: In a timed write, we_n is low from cycle s+1 through the cycle after ACK, and high in the next cycle. data_oe remains high one further cycle, in which ce_n rises and done pulses. data_oe is low afterwards.
- R7: The strobe (oe_n or we_n) asserts in cycle s+1 and the ACK cycle follows w+1 strobe cycles, for any cfg_wait value.
- R8: For cfg_setup=s>0, ce_n is low and both strobes are high for cycles 1..s before the strobe asserts.
- R9: With cfg_dyn=1 and cfg_mode 2 (external-ack) or 3 (ready), ack_pin_oe is low from the cycle ce_n falls through the cycle ce_n rises. It is high again the following cycle.
- R10: In ready mode (cfg_mode=3) the access completes on the first rising edge, after at least w+1 strobe cycles, where ack_pin_i is 1. A high level earlier is ignored. A read captures data_i on that edge and END follows.
- R11: In external-ack mode (cfg_mode=2) the access completes on the first rising edge, after at least w+1 strobe cycles, where ack_pin_i is 0.
- R12: req_ready is high only when idle. A request presented during an access is ignored, so addr_o keeps the accepted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Access address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Controller idle, request accepted this edge if valid |
| cfg_mode | input | 2 | 0 normal, 1 page, 2 external-ack, 3 ready |
| cfg_dyn | input | 1 | 1 = pin direction follows mode, 0 = pin always input |
| cfg_wait | input | 4 | Wait cycles before ACK / minimum wait |
| cfg_setup | input | 4 | Chip-enable-to-strobe setup cycles |
| ack_pin_i | input | 1 | Handshake pin input |
| ack_pin_o | output | 1 | Handshake pin output value (low = ACK) |
| ack_pin_oe | output | 1 | Handshake pin output enable |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| addr_o | output | 20 | External address |
| data_o | output | 32 | External write data |
| data_oe | output | 1 | Data bus output enable |
| data_i | input | 32 | External read data |
| rd_data | output | 32 | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
Timed reads and writes are run with several wait and setup counts. This shows that the ACK pulse, strobe edges and done follow the counts, rather than being fixed positions. During read tests data_i is changed every cycle except the intended capture cycle, which exposes a capture one edge early or late. Device-paced tests hold the pin at the completing level before the minimum wait has elapsed, then delay it past the wait. This separates "ignored early" from "completes on first valid edge", and the same traces show the pin release and re-drive cycles. A static-mode access and a request issued mid-access check that the pin is never driven and that busy requests are dropped.

// File: rtl/ext_cs_pkg.sv
package ext_cs_pkg;

    typedef enum logic [1:0] {
        ACC_NORMAL = 2'd0,
        ACC_PAGE   = 2'd1,
        ACC_EXTACK = 2'd2,
        ACC_READY  = 2'd3
    } acc_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_STRB,
        ST_ACK,
        ST_RLAT,
        ST_WPOST,
        ST_WHOLD,
        ST_END
    } cyc_state_e;

    function automatic logic device_paced(acc_mode_e m);
        return (m == ACC_EXTACK) || (m == ACC_READY);
    endfunction

endpackage

// File: rtl/cs_wait_timer.sv
module cs_wait_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt_q;

    assign hit = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (!hit)   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cs_ackpin_ctrl.sv
module cs_ackpin_ctrl
    import ext_cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cyc_state_e state_q,
    input  cyc_state_e state_d,
    input  acc_mode_e  mode_eff,
    input  logic       dyn_eff,
    output logic       pin_o,
    output logic       pin_oe
);
    logic oe_d;

    // Released from the first chip-enable cycle through the END cycle.
    assign oe_d  = dyn_eff && !(device_paced(mode_eff) && (state_d != ST_IDLE));
    assign pin_o = (state_q != ST_ACK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_oe <= 1'b0;
        else        pin_oe <= oe_d;
    end

    // R3
    ack_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && !pin_o) |=> pin_o);

    // R9
    paced_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && device_paced(mode_eff)) |-> !pin_oe);
endmodule

// File: rtl/ext_cs_cycle_ctrl.sv
module ext_cs_cycle_ctrl
    import ext_cs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 32,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_dyn,
    input  logic [CW-1:0] cfg_wait,
    input  logic [CW-1:0] cfg_setup,
    input  logic          ack_pin_i,
    output logic          ack_pin_o,
    output logic          ack_pin_oe,
    output logic          ce_n,
    output logic          oe_n,
    output logic          we_n,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          data_oe,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] rd_data,
    output logic          done
);
    cyc_state_e    state_q, state_d;
    acc_mode_e     acc_mode, mode_eff;
    logic          acc_dyn, acc_we, dyn_eff;
    logic [CW-1:0] acc_wait, acc_setup, lim;
    logic          hit, dev_ok, paced_done;

    assign mode_eff = (state_q == ST_IDLE) ? acc_mode_e'(cfg_mode) : acc_mode;
    assign dyn_eff  = (state_q == ST_IDLE) ? cfg_dyn : acc_dyn;
    assign lim      = (state_q == ST_ADDR) ? acc_setup - 1'b1 : acc_wait;
    assign dev_ok   = (acc_mode == ACC_READY) ? ack_pin_i : !ack_pin_i;
    assign paced_done = hit && dev_ok;

    cs_wait_timer #(.CW(CW)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .limit (lim),
        .hit   (hit)
    );

    cs_ackpin_ctrl pin_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_q  (state_q),
        .state_d  (state_d),
        .mode_eff (mode_eff),
        .dyn_eff  (dyn_eff),
        .pin_o    (ack_pin_o),
        .pin_oe   (ack_pin_oe)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = (cfg_setup != '0) ? ST_ADDR : ST_STRB;
            ST_ADDR:  if (hit) state_d = ST_STRB;
            ST_STRB: begin
                if (device_paced(acc_mode)) begin
                    if (paced_done) state_d = acc_we ? ST_WHOLD : ST_END;
                end else if (hit) begin
                    state_d = ST_ACK;
                end
            end
            ST_ACK:   state_d = acc_we ? ST_WPOST : ST_RLAT;
            ST_RLAT:  state_d = ST_END;
            ST_WPOST: state_d = ST_WHOLD;
            ST_WHOLD: state_d = ST_END;
            ST_END:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            acc_mode  <= ACC_NORMAL;
            acc_dyn   <= 1'b0;
            acc_we    <= 1'b0;
            acc_wait  <= '0;
            acc_setup <= '0;
            addr_o    <= '0;
            data_o    <= '0;
            rd_data   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                acc_mode  <= acc_mode_e'(cfg_mode);
                acc_dyn   <= cfg_dyn;
                acc_we    <= req_write;
                acc_wait  <= cfg_wait;
                acc_setup <= cfg_setup;
                addr_o    <= req_addr;
                data_o    <= req_wdata;
            end
            if (!acc_we && ((state_q == ST_RLAT) ||
                (state_q == ST_STRB && device_paced(acc_mode) && paced_done)))
                rd_data <= data_i;
        end
    end

    always_comb begin
        ce_n      = 1'b0;
        oe_n      = 1'b1;
        we_n      = 1'b1;
        data_oe   = acc_we;
        done      = 1'b0;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin ce_n = 1'b1; data_oe = 1'b0; req_ready = 1'b1; end
            ST_ADDR:  ;
            ST_STRB, ST_ACK: begin oe_n = acc_we; we_n = !acc_we; end
            ST_RLAT:  oe_n = 1'b0;
            ST_WPOST: we_n = 1'b0;
            ST_WHOLD: ;
            ST_END:   begin ce_n = 1'b1; done = 1'b1; end
            default:  ce_n = 1'b1;
        endcase
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    // R8
    strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> !ce_n);

    // R2
    static_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !acc_dyn) |-> !ack_pin_oe);

    // R12
    busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(addr_o));
endmodule

// File: tb/ext_cs_cycle_ctrl_tb_top.sv
module ext_cs_cycle_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_dyn = 1'b1;
    logic [3:0]  cfg_wait = 4'd2, cfg_setup = 4'd0;
    logic        ack_pin_i = 1'b0;
    logic        ack_pin_o, ack_pin_oe, ce_n, oe_n, we_n, data_oe, done;
    logic [19:0] addr_o;
    logic [31:0] data_o, data_i = '0, rd_data;

    int vec = 0, bad = 0, cyc = 0;

    always #2.5 clk = ~clk;

    ext_cs_cycle_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .cfg_mode(cfg_mode), .cfg_dyn(cfg_dyn), .cfg_wait(cfg_wait),
        .cfg_setup(cfg_setup), .ack_pin_i(ack_pin_i), .ack_pin_o(ack_pin_o),
        .ack_pin_oe(ack_pin_oe), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr_o(addr_o), .data_o(data_o), .data_oe(data_oe), .data_i(data_i),
        .rd_data(rd_data), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int cy,
                       input longint act, input longint exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cy, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    endtask

    // Timed access: trace every cycle against positions derived from s and w.
    task automatic timed_access(input bit wr, input int s, input int w, input bit dyn);
        int ackc = s + w + 2;
        int endc = wr ? s + w + 5 : s + w + 4;
        logic [31:0] good = 32'hA5A5_0000 + 32'(s * 16 + w);
        cfg_mode = 2'd0; cfg_dyn = dyn; cfg_wait = 4'(w); cfg_setup = 4'(s);
        issue(wr, 20'(32'h1000 + w), 32'hD00D_0000 + 32'(w));
        for (int i = 1; i <= endc + 1; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            chk(ce_n == !(i < endc), "R5", i, ce_n, !(i < endc));
            chk(done == (i == endc), "R5", i, done, i == endc);
            if (dyn) begin
                chk(ack_pin_oe == 1'b1, "R3", i, ack_pin_oe, 1);
                chk(ack_pin_o == (i != ackc), "R3", i, ack_pin_o, i != ackc);
            end else begin
                chk(ack_pin_oe == 1'b0, "R2", i, ack_pin_oe, 0);
            end
            if (i <= s) chk(oe_n && we_n, "R8", i, {oe_n, we_n}, 2'b11);
            if (wr) begin
                chk(we_n == !(i > s && i <= ackc + 1), "R6", i, we_n, !(i > s && i <= ackc + 1));
                chk(data_oe == (i <= endc), "R6", i, data_oe, i <= endc);
                chk(oe_n == 1'b1, "R6", i, oe_n, 1);
            end else begin
                chk(oe_n == !(i > s && i <= ackc + 1), "R7", i, oe_n, !(i > s && i <= ackc + 1));
                chk(we_n == 1'b1, "R7", i, we_n, 1);
                data_i = (i == ackc + 1) ? good : ~good;
            end
        end
        if (!wr) chk(rd_data == good, "R4", 0, rd_data, good);
    endtask

    // Device-paced access: pin held at the completing level from cycle early_c,
    // so completion is expected at the edge ending max(w+1, early_c).
    task automatic paced_access(input bit rdy, input int w, input int early_c);
        int compc = (early_c > w + 1) ? early_c : w + 1;
        int endc = compc + 1;
        logic [31:0] good = 32'h5EED_0000 + 32'(early_c);
        cfg_mode = rdy ? 2'd3 : 2'd2; cfg_dyn = 1'b1; cfg_wait = 4'(w); cfg_setup = 4'd0;
        ack_pin_i = !rdy;
        issue(1'b0, 20'h3_0000, '0);
        for (int i = 1; i <= endc + 1; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            chk(ack_pin_oe == (i > endc), "R9", i, ack_pin_oe, i > endc);
            chk(ce_n == !(i < endc), rdy ? "R10" : "R11", i, ce_n, !(i < endc));
            chk(done == (i == endc), rdy ? "R10" : "R11", i, done, i == endc);
            ack_pin_i = (i >= early_c) ? rdy : !rdy;
            data_i = (i == compc) ? good : ~good;
        end
        chk(rd_data == good, rdy ? "R10" : "R11", 0, rd_data, good);
        ack_pin_i = 1'b0;
    endtask

    task automatic busy_request();
        cfg_mode = 2'd0; cfg_dyn = 1'b1; cfg_wait = 4'd2; cfg_setup = 4'd0;
        issue(1'b0, 20'h0_00AA, '0);
        @(negedge clk);
        chk(req_ready == 1'b0, "R12", 1, req_ready, 0);
        req_addr = 20'h0_0055;
        for (int i = 2; i <= 4; i++) begin
            @(negedge clk);
            chk(addr_o == 20'h0_00AA, "R12", i, addr_o, 20'h0_00AA);
        end
        req_valid = 1'b0;
        for (int i = 5; i <= 7; i++) @(negedge clk);
        chk(req_ready == 1'b1, "R12", 7, req_ready, 1);
        chk(addr_o == 20'h0_00AA, "R12", 7, addr_o, 20'h0_00AA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(ce_n && oe_n && we_n, "R1", 0, {ce_n, oe_n, we_n}, 3'b111);
        chk(!done && !ack_pin_oe, "R1", 0, {done, ack_pin_oe}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        timed_access(1'b0, 0, 2, 1'b1);
        timed_access(1'b0, 0, 0, 1'b1);
        timed_access(1'b0, 2, 3, 1'b1);
        timed_access(1'b1, 0, 2, 1'b1);
        timed_access(1'b1, 1, 1, 1'b1);
        timed_access(1'b0, 1, 2, 1'b0);
        paced_access(1'b1, 1, 1);
        paced_access(1'b1, 0, 4);
        paced_access(1'b0, 0, 2);
        paced_access(1'b0, 2, 1);
        busy_request();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            vec++; bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end
endmodule